// File: doc/BRIEF.md
# Byte-Wide Non-Volatile Memory with Timed Page Programming

This block is a clocked model of a byte-wide memory that software reads and writes like a static RAM, but whose writes go through a page buffer and a timed programming phase. Three active-low strobes (chip select, output enable, write enable), a 13-bit address and an 8-bit data path are sampled with the system clock through a two-stage synchroniser. The data path is split into an input byte, an output byte and an output-drive qualifier, so the block can sit behind a tristate pad.

A write cycle places one byte into a 64-entry page buffer, and marks that entry as loaded. Further bytes for the same page may follow in any order, as long as each arrives before a load window runs out. When the window expires, only the marked bytes are copied into the array, and the block then stays busy for a fixed programming time. While it is busy, reads return a poll byte whose top bit is the inverse of the last byte loaded, so software can tell when programming has finished. Write strobes that arrive during programming have no effect. A byte aimed at a different page while a page is open is dropped, and a sticky error flag is raised.

Top module: `nvpg_top`

## Requirements
- R1: With chip select and output enable low and write enable high, and no programming in progress, `rdata_oe` is 1 and `rdata` holds the array byte at the address, three clock edges after the inputs change (two synchroniser stages and one output register).
- R2: Whenever chip select or output enable is high, or write enable is low, `rdata_oe` is 0 and `rdata` is 0 three edges later.
- R3: A write cycle is the interval in which synchronised chip select and write enable are both low and output enable is high. Its address is taken when the interval begins and its data from the last sampled cycle inside it. The byte is loaded when the interval ends, so both the write-enable-pulse form and the chip-select-pulse form work.
- R4: Address bits 12..6 name the page and bits 5..0 the byte in it. The load window restarts at every accepted byte. After LOAD_WIN cycles with no accepted byte, the buffer is committed and the block is busy for PROG_CYC cycles. Reads of the array do not show new data until the commit.
- R5: Bytes of one page may be loaded in any order. A byte loaded twice in one load period keeps the later value.
- R6: After a commit, only the bytes loaded in that period have changed. The other bytes of the page, and of every other page, keep their contents.
- R7: A write whose page differs from the open page is dropped, and `page_err` goes to 1 and stays there until reset.
- R8: A read during programming returns `rdata_oe` = 1 and `rdata` with bit 7 equal to the inverse of bit 7 of the last accepted byte, and bits 6..0 equal to 0.
- R9: A write cycle that ends during programming changes neither the array nor the buffer, and it does not set `page_err`.
- R10: After reset, every array byte reads 0xFF, `rdata`, `rdata_oe` and `page_err` are 0, and no page is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 13 | Byte address (page in 12..6, byte in 5..0) |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data or poll byte, 0 when not driving |
| rdata_oe | output | 1 | High when the data pins should be driven |
| page_err | output | 1 | Sticky flag for a dropped cross-page write |

## Verification
A wrong page tag or a corrupted loaded-byte mask only shows up once the window expires: after that commit, a read of the affected byte, or of a neighbour that should not have changed, returns the wrong value. A window or programming counter that is off by even one cycle moves the edge at which reads switch between array data and the poll byte. Because the reference model is compared on every cycle, that shows up at the first read that straddles the edge. A busy flag that clears too early lets a write strobe land during programming, and a later read of that address exposes it.

// File: rtl/nvpg_pkg.sv
package nvpg_pkg;
    localparam int ADDR_W     = 13;
    localparam int DATA_W     = 8;
    localparam int OFS_W      = 6;
    localparam int PAGE_W     = ADDR_W - OFS_W;
    localparam int PAGE_BYTES = 1 << OFS_W;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] data_t;
    typedef logic [PAGE_W-1:0] page_t;
    typedef logic [OFS_W-1:0]  ofs_t;

    // Pin bundle carried through the synchroniser, controls first.
    typedef struct packed {
        logic  ce_n;
        logic  oe_n;
        logic  we_n;
        addr_t addr;
        data_t data;
    } bus_t;

    // One completed write cycle.
    typedef struct packed {
        logic  stb;
        addr_t addr;
        data_t data;
    } wr_evt_t;

    function automatic page_t page_of(addr_t a);
        return a[ADDR_W-1:OFS_W];
    endfunction

    function automatic ofs_t ofs_of(addr_t a);
        return a[OFS_W-1:0];
    endfunction

    function automatic data_t poll_byte(data_t last);
        data_t s;
        s = '0;
        s[DATA_W-1] = ~last[DATA_W-1];
        return s;
    endfunction
endpackage

// File: rtl/nvpg_sync.sv
module nvpg_sync #(
    parameter int             W       = 8,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] st [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) st[i] <= RST_VAL;
        end else begin
            st[0] <= d;
            for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
        end
    end

    assign q = st[STAGES-1];
endmodule

// File: rtl/nvpg_loader.sv
module nvpg_loader
    import nvpg_pkg::*;
#(
    parameter int LOAD_WIN = 10000
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  wr_evt_t                              evt,
    input  logic                                 busy,
    output logic                                 commit,
    output page_t                                cm_page,
    output logic [PAGE_BYTES-1:0][DATA_W-1:0]    cm_buf,
    output logic [PAGE_BYTES-1:0]                cm_val,
    output data_t                                last_data,
    output logic                                 open,
    output logic                                 page_err
);
    localparam int WIN_W = $clog2(LOAD_WIN + 1);

    logic [PAGE_BYTES-1:0][DATA_W-1:0] buf_q;
    logic [PAGE_BYTES-1:0]             val_q;
    page_t                             page_q;
    logic                              open_q;
    logic [WIN_W-1:0]                  win_q;
    data_t                             last_q;
    logic                              err_q;

    logic same_pg, accept, drop;

    assign same_pg = (page_of(evt.addr) == page_q);
    assign accept  = evt.stb & ~busy & (~open_q | same_pg);
    assign drop    = evt.stb & ~busy & open_q & ~same_pg;
    assign commit  = open_q & ~accept & (win_q == WIN_W'(LOAD_WIN - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_q  <= '0;
            val_q  <= '0;
            page_q <= '0;
            open_q <= 1'b0;
            win_q  <= '0;
            last_q <= '0;
            err_q  <= 1'b0;
        end else begin
            if (drop) err_q <= 1'b1;
            if (accept) begin
                buf_q[ofs_of(evt.addr)] <= evt.data;
                val_q[ofs_of(evt.addr)] <= 1'b1;
                page_q <= page_of(evt.addr);
                open_q <= 1'b1;
                win_q  <= '0;
                last_q <= evt.data;
            end else if (commit) begin
                val_q  <= '0;
                open_q <= 1'b0;
                win_q  <= '0;
            end else if (open_q) begin
                win_q <= win_q + 1'b1;
            end
        end
    end

    assign cm_page   = page_q;
    assign cm_buf    = buf_q;
    assign cm_val    = val_q;
    assign last_data = last_q;
    assign open      = open_q;
    assign page_err  = err_q;

    // R7: the cross-page error flag never clears on its own
    a_r7_err_sticky: assert property (@(posedge clk) disable iff (rst)
        err_q |=> err_q);
    // R4: the window counter stays inside the window while a page is open
    a_r4_win_bound: assert property (@(posedge clk) disable iff (rst)
        open_q |-> (win_q < WIN_W'(LOAD_WIN)));
    // R9: nothing is held in the buffer while programming runs
    a_r9_busy_buf_empty: assert property (@(posedge clk) disable iff (rst)
        busy |-> (val_q == '0));
endmodule

// File: rtl/nvpg_core.sv
module nvpg_core
    import nvpg_pkg::*;
#(
    parameter int PROG_CYC = 1000000,
    parameter int ARR_AW   = 10
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              commit,
    input  page_t                             cm_page,
    input  logic [PAGE_BYTES-1:0][DATA_W-1:0] cm_buf,
    input  logic [PAGE_BYTES-1:0]             cm_val,
    input  data_t                             last_data,
    input  logic                              rd_act,
    input  addr_t                             rd_addr,
    output logic                              busy,
    output data_t                             rdata,
    output logic                              rdata_oe
);
    localparam int DEPTH = 1 << ARR_AW;
    localparam int PRG_W = $clog2(PROG_CYC + 1);

    data_t            mem [DEPTH];
    logic             busy_q;
    logic [PRG_W-1:0] prog_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else if (commit) begin
            for (int j = 0; j < PAGE_BYTES; j++) begin
                if (cm_val[j]) mem[ARR_AW'({cm_page, OFS_W'(j)})] <= cm_buf[j];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            prog_q <= '0;
        end else if (commit) begin
            busy_q <= 1'b1;
            prog_q <= '0;
        end else if (busy_q) begin
            if (prog_q == PRG_W'(PROG_CYC - 1)) busy_q <= 1'b0;
            else                                prog_q <= prog_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata    <= '0;
            rdata_oe <= 1'b0;
        end else begin
            rdata_oe <= rd_act;
            if (!rd_act)     rdata <= '0;
            else if (busy_q) rdata <= poll_byte(last_data);
            else             rdata <= mem[ARR_AW'(rd_addr)];
        end
    end

    assign busy = busy_q;

    // R4: programming ends only after the full programming time
    a_r4_prog_len: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_q) |-> ($past(prog_q) == PRG_W'(PROG_CYC - 1)));
    // R9: the loader never commits into a running programming phase
    a_r9_no_commit_busy: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> !commit);
    // R8: a poll byte carries only the status bit
    a_r8_poll_low: assert property (@(posedge clk) disable iff (rst)
        (rdata_oe && $past(busy_q)) |-> (rdata[DATA_W-2:0] == '0));
endmodule

// File: rtl/nvpg_top.sv
module nvpg_top
    import nvpg_pkg::*;
#(
    parameter int LOAD_WIN = 10000,
    parameter int PROG_CYC = 1000000,
    parameter int ARR_AW   = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_oe,
    output logic              page_err
);
    localparam logic [$bits(bus_t)-1:0] BUS_IDLE = {3'b111, {(ADDR_W + DATA_W){1'b0}}};

    bus_t    raw, bs;
    logic    wr_act, rd_act, wr_prev;
    addr_t   lat_addr;
    data_t   lat_data;
    wr_evt_t evt;

    logic                              commit, busy, open;
    page_t                             cm_page;
    logic [PAGE_BYTES-1:0][DATA_W-1:0] cm_buf;
    logic [PAGE_BYTES-1:0]             cm_val;
    data_t                             last_data;

    assign raw = {ce_n, oe_n, we_n, addr, wdata};

    nvpg_sync #(.W($bits(bus_t)), .STAGES(2), .RST_VAL(BUS_IDLE)) u_sync (
        .clk(clk), .rst(rst), .d(raw), .q(bs));

    assign wr_act = ~bs.ce_n & ~bs.we_n & bs.oe_n;
    assign rd_act = ~bs.ce_n & ~bs.oe_n & bs.we_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_prev  <= 1'b0;
            lat_addr <= '0;
            lat_data <= '0;
        end else begin
            wr_prev <= wr_act;
            if (wr_act && !wr_prev) lat_addr <= bs.addr;
            if (wr_act)             lat_data <= bs.data;
        end
    end

    assign evt.stb  = wr_prev & ~wr_act;
    assign evt.addr = lat_addr;
    assign evt.data = lat_data;

    nvpg_loader #(.LOAD_WIN(LOAD_WIN)) u_loader (
        .clk(clk), .rst(rst), .evt(evt), .busy(busy), .commit(commit),
        .cm_page(cm_page), .cm_buf(cm_buf), .cm_val(cm_val),
        .last_data(last_data), .open(open), .page_err(page_err));

    nvpg_core #(.PROG_CYC(PROG_CYC), .ARR_AW(ARR_AW)) u_core (
        .clk(clk), .rst(rst), .commit(commit), .cm_page(cm_page),
        .cm_buf(cm_buf), .cm_val(cm_val), .last_data(last_data),
        .rd_act(rd_act), .rd_addr(bs.addr), .busy(busy),
        .rdata(rdata), .rdata_oe(rdata_oe));

    // R2: an undriven data path carries zero
    a_r2_release: assert property (@(posedge clk) disable iff (rst)
        !rdata_oe |-> (rdata == '0));
    // R9: a page is never open while programming runs
    a_r9_open_excl: assert property (@(posedge clk) disable iff (rst)
        busy |-> !open);
endmodule

// File: tb/nvpg_top_bench.sv
module nvpg_top_bench;
    localparam int LW = 20;
    localparam int PC = 60;
    localparam int AW = 10;
    localparam int DEPTH = 1 << AW;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [12:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        rdata_oe;
    logic        page_err;

    int n_chk = 0;
    int n_bad = 0;
    string cur_req = "R10";

    always #5 clk = ~clk;

    nvpg_top #(.LOAD_WIN(LW), .PROG_CYC(PC), .ARR_AW(AW)) u_nvpg_top (
        .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe),
        .page_err(page_err));

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Behavioural reference: pins seen two edges late, write events, page list, timers.
    int m_mem [DEPTH];
    int m_buf [64];
    bit m_val [64];
    int q_ce[2], q_oe[2], q_we[2], q_a[2], q_d[2];
    bit m_wprev, m_open, m_busy, m_err;
    int m_lat_a, m_lat_d, m_page, m_win, m_prog, m_last;
    int ex_out, ex_oe;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) m_mem[i] = 'hFF;
            for (int j = 0; j < 64; j++) m_val[j] = 0;
            for (int k = 0; k < 2; k++) begin
                q_ce[k] = 1; q_oe[k] = 1; q_we[k] = 1; q_a[k] = 0; q_d[k] = 0;
            end
            m_wprev = 0; m_open = 0; m_busy = 0; m_err = 0;
            m_lat_a = 0; m_lat_d = 0; m_page = 0; m_win = 0; m_prog = 0; m_last = 0;
            ex_out = 0; ex_oe = 0;
        end else begin
            bit wa, rd, stb, acc, comm, nbusy;
            wa = (q_ce[1] == 0) && (q_we[1] == 0) && (q_oe[1] == 1);
            rd = (q_ce[1] == 0) && (q_oe[1] == 0) && (q_we[1] == 1);
            ex_oe  = rd;
            ex_out = !rd ? 0 : (m_busy ? ((m_last & 'h80) ^ 'h80) : m_mem[q_a[1] % DEPTH]);
            stb = m_wprev && !wa;
            acc = 0;
            if (stb && !m_busy) begin
                if (!m_open || (m_lat_a >> 6) == m_page) acc = 1;
                else m_err = 1;
            end
            comm = m_open && !acc && (m_win == LW - 1);
            nbusy = m_busy;
            if (comm) begin
                for (int j = 0; j < 64; j++)
                    if (m_val[j]) m_mem[(m_page * 64 + j) % DEPTH] = m_buf[j];
                nbusy = 1; m_prog = 0;
            end else if (m_busy) begin
                if (m_prog == PC - 1) nbusy = 0;
                else m_prog++;
            end
            if (acc) begin
                m_buf[m_lat_a % 64] = m_lat_d;
                m_val[m_lat_a % 64] = 1;
                m_page = m_lat_a >> 6;
                m_open = 1; m_win = 0; m_last = m_lat_d;
            end else if (comm) begin
                for (int j = 0; j < 64; j++) m_val[j] = 0;
                m_open = 0; m_win = 0;
            end else if (m_open) begin
                m_win++;
            end
            m_busy = nbusy;
            if (wa && !m_wprev) m_lat_a = q_a[1];
            if (wa) m_lat_d = q_d[1];
            m_wprev = wa;
            q_ce[1] = q_ce[0]; q_oe[1] = q_oe[0]; q_we[1] = q_we[0];
            q_a[1] = q_a[0]; q_d[1] = q_d[0];
            q_ce[0] = ce_n; q_oe[0] = oe_n; q_we[0] = we_n; q_a[0] = addr; q_d[0] = wdata;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            chk(cur_req, "model rdata", rdata, ex_out);
            chk(cur_req, "model rdata_oe", rdata_oe, ex_oe);
            chk(cur_req, "model page_err", page_err, m_err);
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_we(input int a, input int d);
        @(negedge clk);
        addr = a; wdata = d; oe_n = 1; ce_n = 0; we_n = 0;
        idle(3);
        we_n = 1;
        idle(2);
        ce_n = 1;
    endtask

    task automatic wr_ce(input int a, input int d);
        @(negedge clk);
        addr = a; wdata = d; oe_n = 1; we_n = 0;
        idle(1);
        ce_n = 0;
        idle(3);
        ce_n = 1;
        idle(1);
        we_n = 1;
    endtask

    task automatic rd(input int a, output int v, output int o);
        @(negedge clk);
        addr = a; we_n = 1; ce_n = 0; oe_n = 0;
        idle(4);
        v = rdata; o = rdata_oe;
        ce_n = 1; oe_n = 1;
    endtask

    task automatic rd_chk(input string req, input int a, input int exp);
        int v, o;
        rd(a, v, o);
        chk(req, $sformatf("read %0h", a), v, exp);
        chk(req, "drive during read", o, 1);
    endtask

    task automatic summary;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog run did not finish");
        summary();
        $finish;
    end

    initial begin
        idle(3);
        rst = 0;
        // R10: reset state
        cur_req = "R10";
        @(negedge clk);
        chk("R10", "rdata after reset", rdata, 0);
        chk("R10", "rdata_oe after reset", rdata_oe, 0);
        chk("R10", "page_err after reset", page_err, 0);
        rd_chk("R10", 13'h005, 'hFF);
        cur_req = "R1";
        rd_chk("R1", 13'h3FF, 'hFF);

        // R2: no drive with chip select high, or with output enable high
        cur_req = "R2";
        @(negedge clk);
        addr = 13'h005; ce_n = 1; oe_n = 0; we_n = 1;
        idle(4);
        chk("R2", "rdata_oe ce high", rdata_oe, 0);
        chk("R2", "rdata ce high", rdata, 0);
        ce_n = 0; oe_n = 1;
        idle(4);
        chk("R2", "rdata_oe oe high", rdata_oe, 0);
        ce_n = 1;

        // R3/R8: single byte, poll during programming
        cur_req = "R3";
        wr_we(13'h010, 'h3C);
        rd_chk("R4", 13'h010, 'hFF);
        idle(22);
        cur_req = "R8";
        rd_chk("R8", 13'h011, 'h80);
        idle(LW + PC);
        cur_req = "R3";
        rd_chk("R3", 13'h010, 'h3C);
        rd_chk("R6", 13'h011, 'hFF);

        // R5/R7: out-of-order page, overwrite, cross-page drop
        cur_req = "R5";
        wr_we(13'h085, 'h11);
        wr_we(13'h081, 'h22);
        wr_we(13'h085, 'hA5);
        cur_req = "R7";
        wr_we(13'h0C3, 'h77);
        idle(2);
        chk("R7", "page_err after cross-page write", page_err, 1);
        idle(20);
        rd_chk("R8", 13'h085, 'h00);
        idle(LW + PC);
        cur_req = "R5";
        rd_chk("R5", 13'h085, 'hA5);
        rd_chk("R5", 13'h081, 'h22);
        rd_chk("R7", 13'h0C3, 'hFF);
        rd_chk("R6", 13'h082, 'hFF);
        chk("R7", "page_err held", page_err, 1);

        // R9: write during programming
        cur_req = "R9";
        wr_we(13'h100, 'h55);
        idle(22);
        wr_we(13'h101, 'h66);
        idle(LW + PC);
        rd_chk("R9", 13'h101, 'hFF);
        rd_chk("R9", 13'h100, 'h55);

        // R4/R3: window restarts per byte, chip-select controlled write
        cur_req = "R4";
        wr_we(13'h180, 'h0F);
        idle(10);
        wr_ce(13'h181, 'h1E);
        idle(10);
        wr_we(13'h182, 'h2D);
        rd_chk("R4", 13'h180, 'hFF);
        idle(20);
        rd_chk("R4", 13'h182, 'h80);
        idle(LW + PC);
        rd_chk("R4", 13'h180, 'h0F);
        rd_chk("R3", 13'h181, 'h1E);
        rd_chk("R4", 13'h182, 'h2D);

        // R10: second reset clears flag and array
        @(negedge clk);
        rst = 1;
        idle(2);
        rst = 0;
        cur_req = "R10";
        @(negedge clk);
        chk("R10", "page_err after second reset", page_err, 0);
        rd_chk("R10", 13'h100, 'hFF);

        idle(5);
        summary();
        $finish;
    end
endmodule